// File: doc/BRIEF.md
# Text Cursor Shape Generator

This block produces the one-bit text cursor overlay while a text screen is being scanned out. The character generator presents, on every pixel-clock cycle, the linear index of the character cell being drawn and the scan line within that cell. The block compares these against a cursor address and a cursor shape that software has already loaded into registers elsewhere. It raises the overlay when the beam is inside the cursor cell and inside the programmed band of lines, during the visible half of the blink cycle.

The cursor address is a linear index, row times the line width plus column. The shape is a band from a start line to an end line, both counted from the top of the cell. The band is clipped to the cell height, which is given as the line count minus one. Blinking is timed in frames: a frame strobe advances a counter, and after the programmed number of frames the visible and hidden phases swap. A steady bit freezes the cursor in its visible state. A separate enable bit hides the cursor whatever its shape, and software clears it when it asks for a cursor of zero height.

Top module: `cursor_overlay_gen`

## Requirements
- R1: While `csr_show` is 0, `cursor_on` is 0 on the following cycle, for any address, line or blink state.
- R2: `cursor_on` can be 1 only when `char_addr` equals `csr_addr`. A cursor address of 2000 gives no overlay over character indices 0 to 1999 of an 80x25 screen.
- R3: With the other conditions met, `cursor_on` is 1 exactly on the scan lines L for which `csr_top` <= L <= `csr_bottom`, both ends included.
- R4: When `csr_top` is greater than `csr_bottom`, no scan line of the cell shows the cursor.
- R5: Scan lines greater than `csr_cell_m1` (the cell height minus one) never show the cursor, even when they lie inside the start-to-end band.
- R6: When `csr_steady` is 1, the cursor stays visible on every frame, whatever frame strobes arrive.
- R7: When `csr_steady` is 0 and `csr_period` is N (1 to 31), the blink phase changes after every N frame strobes and holds between strobes. The frame count returns to zero at each change.
- R8: A `csr_period` of 0 behaves as 1: every frame strobe swaps the blink phase.
- R9: While `rst` is 1, `cursor_on` is 0. Reset leaves the blink phase visible and the frame count at zero, so the first N-1 strobes after reset keep the cursor visible.
- R10: `cursor_on` is registered. It reflects the inputs present at the previous rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/character clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_show | input | 1 | Cursor enable |
| csr_cell_m1 | input | 5 | Cell height minus one |
| csr_top | input | 5 | First scan line of the cursor band |
| csr_bottom | input | 5 | Last scan line of the cursor band |
| csr_steady | input | 1 | 1 = no blinking, cursor always visible |
| csr_period | input | 5 | Frames per blink phase (0 treated as 1) |
| csr_addr | input | 16 | Linear character index of the cursor |
| char_addr | input | 16 | Linear index of the character being scanned |
| scan_line | input | 5 | Scan line within the current cell |
| frame_strobe | input | 1 | One-cycle pulse per frame |
| cursor_on | output | 1 | Registered cursor overlay |

## Verification
The assertions check on every cycle that the overlay stays low when the cursor is disabled, when the addresses differ, when the band is inverted or the line lies outside the cell, and that steady mode with all conditions met raises it. They also check that the blink phase never moves without a strobe and that a period of 0 swaps it on every strobe. Only the bench's scenarios can show the exact band edges across a full line sweep, the count of strobes between phase swaps for a given period, the visible phase left by reset, and the single cycle of output latency.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef enum logic {
    PH_HIDE = 1'b0,
    PH_SHOW = 1'b1
  } blink_phase_e;

endpackage

// File: rtl/cursor_blink_timer.sv
module cursor_blink_timer
  import cursor_pkg::*;
#(
  parameter int RATE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_strobe,
  input  logic [RATE_W-1:0] rate_i,
  output logic              visible_o
);

  localparam int CNT_W = RATE_W + 1;

  logic [RATE_W-1:0] cnt_q;
  blink_phase_e      phase_q;
  logic [CNT_W-1:0]  rate_eff;
  logic [CNT_W-1:0]  cnt_inc;
  logic              wrap;

  always_comb begin
    rate_eff = (rate_i == '0) ? CNT_W'(1) : {1'b0, rate_i};
    cnt_inc  = {1'b0, cnt_q} + CNT_W'(1);
    wrap     = (cnt_inc >= rate_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= PH_SHOW;
    end else if (frame_strobe) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_SHOW) ? PH_HIDE : PH_SHOW;
      end else begin
        cnt_q <= cnt_inc[RATE_W-1:0];
      end
    end
  end

  assign visible_o = (phase_q == PH_SHOW);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (phase_q == PH_SHOW && cnt_q == '0));

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |=> $stable(phase_q));

  // R8
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && rate_i == '0) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/cursor_band_check.sv
module cursor_band_check #(
  parameter int LINE_W = 5
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] top_i,
  input  logic [LINE_W-1:0] bottom_i,
  input  logic [LINE_W-1:0] cell_m1_i,
  output logic              in_band_o
);

  logic below_top;
  logic above_bottom;
  logic past_cell;

  always_comb begin
    below_top    = (line_i < top_i);
    above_bottom = (line_i > bottom_i);
    past_cell    = (line_i > cell_m1_i);
    in_band_o    = !below_top && !above_bottom && !past_cell;
  end

endmodule

// File: rtl/cursor_addr_match.sv
module cursor_addr_match #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);

  logic [ADDR_W-1:0] bit_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &bit_eq;

endmodule

// File: rtl/cursor_overlay_gen.sv
module cursor_overlay_gen #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 5,
  parameter int RATE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_show,
  input  logic [LINE_W-1:0] csr_cell_m1,
  input  logic [LINE_W-1:0] csr_top,
  input  logic [LINE_W-1:0] csr_bottom,
  input  logic              csr_steady,
  input  logic [RATE_W-1:0] csr_period,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [ADDR_W-1:0] char_addr,
  input  logic [LINE_W-1:0] scan_line,
  input  logic              frame_strobe,
  output logic              cursor_on
);

  logic addr_hit;
  logic line_hit;
  logic blink_vis;
  logic overlay_d;

  cursor_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .a_i  (char_addr),
    .b_i  (csr_addr),
    .eq_o (addr_hit)
  );

  cursor_band_check #(.LINE_W(LINE_W)) u_band (
    .line_i    (scan_line),
    .top_i     (csr_top),
    .bottom_i  (csr_bottom),
    .cell_m1_i (csr_cell_m1),
    .in_band_o (line_hit)
  );

  cursor_blink_timer #(.RATE_W(RATE_W)) u_blink (
    .clk          (clk),
    .rst          (rst),
    .frame_strobe (frame_strobe),
    .rate_i       (csr_period),
    .visible_o    (blink_vis)
  );

  assign overlay_d = csr_show && addr_hit && line_hit && (csr_steady || blink_vis);

  always_ff @(posedge clk) begin
    if (rst) cursor_on <= 1'b0;
    else     cursor_on <= overlay_d;
  end

  // R1
  hidden_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_show |=> !cursor_on);

  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (char_addr != csr_addr) |=> !cursor_on);

  // R4
  inverted_band_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_top > csr_bottom) |=> !cursor_on);

  // R5
  outside_cell_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_line > csr_cell_m1) |=> !cursor_on);

  // R6
  steady_on_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_show && csr_steady && char_addr == csr_addr &&
     scan_line >= csr_top && scan_line <= csr_bottom &&
     scan_line <= csr_cell_m1) |=> cursor_on);

endmodule

// File: tb/cursor_overlay_gen_tb.sv
`timescale 1ns/1ps
module cursor_overlay_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_show = 1'b0;
  logic [4:0]  csr_cell_m1 = 5'd15;
  logic [4:0]  csr_top = 5'd0;
  logic [4:0]  csr_bottom = 5'd15;
  logic        csr_steady = 1'b1;
  logic [4:0]  csr_period = 5'd12;
  logic [15:0] csr_addr = 16'd0;
  logic [15:0] char_addr = 16'd0;
  logic [4:0]  scan_line = 5'd0;
  logic        frame_strobe = 1'b0;
  logic        cursor_on;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cursor_overlay_gen u_dut (
    .clk(clk), .rst(rst), .csr_show(csr_show), .csr_cell_m1(csr_cell_m1),
    .csr_top(csr_top), .csr_bottom(csr_bottom), .csr_steady(csr_steady),
    .csr_period(csr_period), .csr_addr(csr_addr), .char_addr(char_addr),
    .scan_line(scan_line), .frame_strobe(frame_strobe), .cursor_on(cursor_on)
  );

  task automatic chk(input string req, input logic exp);
    n_checks++;
    if (cursor_on !== exp) begin
      n_fail++;
      $display("FAIL %s: cursor_on=%b expected %b (t=%0t)", req, cursor_on, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    frame_strobe = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic pulse();
    frame_strobe = 1'b1;
    step();
    frame_strobe = 1'b0;
    step();
  endtask

  task automatic all_match();
    csr_show = 1'b1; csr_cell_m1 = 5'd15; csr_top = 5'd0; csr_bottom = 5'd15;
    csr_steady = 1'b1; csr_addr = 16'd100; char_addr = 16'd100; scan_line = 5'd5;
  endtask

  task automatic t_reset();
    all_match();
    rst = 1'b1;
    step(); step();
    chk("R9 output low in reset", 1'b0);
    rst = 1'b0; csr_steady = 1'b0; csr_period = 5'd4;
    step();
    chk("R9 phase visible after reset", 1'b1);
  endtask

  task automatic t_latency();
    all_match(); char_addr = 16'd7;
    step();
    chk("R10 baseline", 1'b0);
    char_addr = 16'd100;
    #1;
    chk("R10 no change before edge", 1'b0);
    step();
    chk("R10 one cycle later", 1'b1);
  endtask

  task automatic t_enable();
    all_match(); csr_show = 1'b0;
    step();
    chk("R1 disabled", 1'b0);
    csr_show = 1'b1;
    step();
    chk("R1 re-enabled", 1'b1);
  endtask

  task automatic t_addr();
    all_match(); csr_addr = 16'd2000;
    for (int a = 0; a < 2000; a++) begin
      char_addr = 16'(a);
      step();
      chk("R2 address 2000 off-screen", 1'b0);
    end
    csr_addr = 16'd1234;
    for (int a = 1230; a < 1240; a++) begin
      char_addr = 16'(a);
      step();
      chk("R2 address compare", (a == 1234));
    end
  endtask

  task automatic t_band();
    all_match(); csr_top = 5'd3; csr_bottom = 5'd6;
    for (int l = 0; l < 16; l++) begin
      scan_line = 5'(l);
      step();
      chk("R3 band 3..6", (l >= 3 && l <= 6));
    end
  endtask

  task automatic t_inverted();
    all_match(); csr_top = 5'd9; csr_bottom = 5'd4;
    for (int l = 0; l < 32; l++) begin
      scan_line = 5'(l);
      step();
      chk("R4 inverted band", 1'b0);
    end
  endtask

  task automatic t_cell();
    all_match(); csr_cell_m1 = 5'd7; csr_top = 5'd2; csr_bottom = 5'd20;
    for (int l = 0; l < 32; l++) begin
      scan_line = 5'(l);
      step();
      chk("R5 clipped to cell", (l >= 2 && l <= 7));
    end
  endtask

  task automatic t_steady();
    do_reset();
    all_match(); csr_period = 5'd1;
    step();
    for (int k = 0; k < 3; k++) begin
      pulse();
      chk("R6 steady stays visible", 1'b1);
    end
  endtask

  task automatic t_blink();
    do_reset();
    all_match(); csr_steady = 1'b0; csr_period = 5'd3;
    step();
    chk("R7 start visible", 1'b1);
    for (int k = 1; k <= 9; k++) begin
      pulse();
      chk("R7 period 3 phase", ((k / 3) % 2) == 0);
    end
    repeat (5) step();
    chk("R7 holds without strobe", 1'b0);
  endtask

  task automatic t_zero_rate();
    do_reset();
    all_match(); csr_steady = 1'b0; csr_period = 5'd0;
    step();
    for (int k = 1; k <= 4; k++) begin
      pulse();
      chk("R8 rate 0 toggles each frame", (k % 2) == 0);
    end
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_latency();
    t_enable();
    t_addr();
    t_band();
    t_inverted();
    t_cell();
    t_steady();
    t_blink();
    t_zero_rate();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule